// File: doc/BRIEF.md
# Wiper Register Bank with Power-Up Recall

This block keeps the digital state behind a single tap selector. One volatile 10-bit wiper register sets which of 1024 tap switches is closed. Four 10-bit storage slots model retained memory. A serial front end issues commands over a one-cycle command strobe. A command can read or write the wiper, read or write a storage slot, copy a slot into the wiper (load), or copy the wiper into a slot (save). Each command gets a response one cycle later with an accept flag and any read data.

Storage slot 0 is the power-up default. While reset is held, its value is copied into the wiper. The slots themselves are not cleared by reset. They start from a parameter value and keep whatever was last saved, so a later reset recalls the new value.

Any write into storage is a direct slot write or a save. Such a write is blocked while the active-low protect input is low. An accepted storage write starts a busy period of a fixed length, and the front end uses the busy flag to poll for completion. The wiper register is writable at all times. The registered one-hot output drives the tap switches.

Top module: `wiper_bank`

## Requirements
- R1: While `rst` is high, the wiper register takes the value of storage slot 0; storage slots keep their contents across reset, so after reset the wiper equals the last value stored in slot 0 (or the slot-0 part of `INIT` if none was stored).
- R2: `tap_sel` is always exactly one-hot, with bit `wiper` set; wiper 0x000 selects bit 0 (low end), 0x3FF selects bit 1023 (high end).
- R3: A write command (`cmd_op`=1) with `cmd_wiper`=1 loads `cmd_wdata` into the wiper on the next cycle and is accepted whatever the states of `wp_n` and `busy`.
- R4: A read command (`cmd_op`=0) returns the wiper (`cmd_wiper`=1) or slot `cmd_idx` (`cmd_wiper`=0) on `rsp_data` one cycle later, with `rsp_ok`=1; every other command returns `rsp_data`=0.
- R5: A write command with `cmd_wiper`=0, `wp_n`=1 and `busy`=0 stores `cmd_wdata` into slot `cmd_idx` and is accepted.
- R6: While `wp_n` is low, a slot write or save is rejected (`rsp_ok`=0), and the slot is left unchanged.
- R7: An accepted slot write or save raises `busy` on the next cycle, and `busy` stays high for exactly `BUSY_CYCLES` cycles.
- R8: While `busy` is high, a slot write or save is rejected, and the slot is left unchanged.
- R9: A load command (`cmd_op`=2) copies slot `cmd_idx` into the wiper and is accepted even while protected or busy.
- R10: A save command (`cmd_op`=3) copies the wiper into slot `cmd_idx` and counts as a storage write under R6, R7 and R8.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `cmd_valid` high and reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, recalls slot 0 into the wiper |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 load slot to wiper, 3 save wiper to slot |
| cmd_wiper | input | 1 | For read and write: 1 targets the wiper, 0 targets a slot |
| cmd_idx | input | 2 | Storage slot index |
| cmd_wdata | input | 10 | Write data |
| wp_n | input | 1 | Storage write enable, low blocks storage writes |
| busy | output | 1 | Storage write in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Command accepted |
| rsp_data | output | 10 | Read data |
| wiper | output | 10 | Current wiper value |
| tap_sel | output | 1024 | One-hot tap switch select |

## Verification
The bench builds the block with `BUSY_CYCLES`=6 and an `INIT` that puts 0x3FF in slot 0. With this short busy window, many random commands land inside the window and are rejected, and many land after it ends. With 0x3FF in slot 0, the first reset recall lands on the high-end tap. A save into slot 0 followed by a second reset shows that the slot keeps its value across reset and that the recall follows the saved value.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOAD = 2'd2,
    OP_SAVE = 2'd3
  } wiper_op_e;
endpackage

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4,
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] rdata0
);
  // retained slots: no reset, start from INIT
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata  = mem[raddr];
  assign rdata0 = mem[0];
endmodule

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int BUSY_CYCLES = 64,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (start) cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder #(
  parameter int WIDTH = 10,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] value_d,
  output logic [TAPS-1:0]  tap_q
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) tap_q[t] <= (value_d == WIDTH'(t));
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int NUM_DR = 4,
  parameter int BUSY_CYCLES = 64,
  parameter logic [NUM_DR*WIDTH-1:0] INIT = '0,
  localparam int IDX_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wiper,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [WIDTH-1:0] cmd_wdata,
  input  logic             wp_n,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [WIDTH-1:0] rsp_data,
  output logic [WIDTH-1:0] wiper,
  output logic [TAPS-1:0]  tap_sel
);
  wiper_op_e op;
  logic [WIDTH-1:0] slot_rd, slot0_rd, wiper_q, wiper_d, store_wdata;
  logic store_req, store_go, accept;

  assign op = wiper_op_e'(cmd_op);

  // storage writes: direct slot write or save of the wiper
  assign store_req = cmd_valid && !rst &&
                     ((op == OP_WRITE && !cmd_wiper) || op == OP_SAVE);
  assign store_go  = store_req && wp_n && !busy;
  assign accept    = cmd_valid && (!store_req || store_go);
  assign store_wdata = (op == OP_SAVE) ? wiper_q : cmd_wdata;

  wiper_store #(.WIDTH(WIDTH), .DEPTH(NUM_DR), .INIT(INIT)) i_store (
    .clk(clk), .we(store_go), .waddr(cmd_idx), .wdata(store_wdata),
    .raddr(cmd_idx), .rdata(slot_rd), .rdata0(slot0_rd)
  );

  wiper_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
    .clk(clk), .rst(rst), .start(store_go), .busy(busy)
  );

  always_comb begin
    wiper_d = wiper_q;
    if (rst) wiper_d = slot0_rd;
    else if (cmd_valid && op == OP_WRITE && cmd_wiper) wiper_d = cmd_wdata;
    else if (cmd_valid && op == OP_LOAD) wiper_d = slot_rd;
  end

  always_ff @(posedge clk) wiper_q <= wiper_d;

  wiper_tap_decoder #(.WIDTH(WIDTH)) i_dec (
    .clk(clk), .value_d(wiper_d), .tap_q(tap_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_ok    <= accept;
      rsp_data  <= (cmd_valid && op == OP_READ) ?
                   (cmd_wiper ? wiper_q : slot_rd) : '0;
    end
  end

  assign wiper = wiper_q;
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int WIDTH = 10,
  parameter int IDX_W = 2,
  parameter int TAPS = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             cmd_wiper,
  input logic [IDX_W-1:0] cmd_idx,
  input logic [WIDTH-1:0] cmd_wdata,
  input logic             wp_n,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic [WIDTH-1:0] rsp_data,
  input logic [WIDTH-1:0] wiper,
  input logic [TAPS-1:0]  tap_sel
);
  logic st_cmd;
  assign st_cmd = cmd_valid && ((cmd_op == 2'd1 && !cmd_wiper) || cmd_op == 2'd3);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot(tap_sel));
  p_tap_match_r2: assert property (@(posedge clk) disable iff (rst)
    tap_sel[wiper]);
  p_wiper_write_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && cmd_wiper) |=> (wiper == $past(cmd_wdata) && rsp_ok));
  p_protect_r6: assert property (@(posedge clk) disable iff (rst)
    (st_cmd && !wp_n) |=> !rsp_ok);
  p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    (st_cmd && wp_n && !busy) |=> (busy && rsp_ok));
  p_busy_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (st_cmd && busy) |=> !rsp_ok);
  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);
endmodule

bind wiper_bank wiper_bank_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .TAPS(TAPS)) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_wiper(cmd_wiper), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
  .wp_n(wp_n), .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
  .rsp_data(rsp_data), .wiper(wiper), .tap_sel(tap_sel)
);

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
  localparam int W = 10;
  localparam int N = 4;
  localparam int BC = 6;
  localparam logic [N*W-1:0] INIT_V = {10'h0A5, 10'h2C3, 10'h001, 10'h3FF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_wiper = 1'b0;
  logic [1:0] cmd_idx = 2'd0;
  logic [W-1:0] cmd_wdata = '0;
  logic wp_n = 1'b1;
  logic busy, rsp_valid, rsp_ok;
  logic [W-1:0] rsp_data, wiper;
  logic [(1<<W)-1:0] tap_sel;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic [W-1:0] m_dr [N];
  logic [W-1:0] m_wip;
  int m_busy = 0;

  always #5 clk = ~clk;

  wiper_bank #(.WIDTH(W), .NUM_DR(N), .BUSY_CYCLES(BC), .INIT(INIT_V)) i_wiper_bank (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wiper(cmd_wiper), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .wp_n(wp_n), .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_data(rsp_data), .wiper(wiper), .tap_sel(tap_sel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_store(logic [1:0] op, logic wsel);
    return (op == 2'd1 && !wsel) || op == 2'd3;
  endfunction

  task automatic chk_state(string req);
    chk({req, " wiper"}, 32'(wiper), 32'(m_wip));
    chk("R2 onehot", 32'($onehot(tap_sel)), 32'd1);
    chk("R2 tap", 32'(tap_sel[m_wip]), 32'd1);
    chk("R7 busy", 32'(busy), 32'(m_busy != 0));
  endtask

  // caller sits just after a negedge
  task automatic cmd(logic [1:0] op, logic wsel, logic [1:0] idx, logic [W-1:0] d, string req);
    bit st, ok;
    logic [W-1:0] exp_rd;
    cmd_valid = 1'b1; cmd_op = op; cmd_wiper = wsel; cmd_idx = idx; cmd_wdata = d;
    st = is_store(op, wsel);
    ok = !st || (wp_n && m_busy == 0);
    exp_rd = (op == 2'd0) ? (wsel ? m_wip : m_dr[idx]) : '0;
    @(posedge clk);
    if (op == 2'd1 && wsel) m_wip = d;
    if (op == 2'd2) m_wip = m_dr[idx];
    if (st && ok) begin
      m_dr[idx] = (op == 2'd3) ? m_wip : d;
      m_busy = BC;
    end else if (m_busy > 0) m_busy--;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    chk({req, " ok"}, 32'(rsp_ok), 32'(ok));
    chk({req, " R4 data"}, 32'(rsp_data), 32'(exp_rd));
    chk_state(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cmd_valid = 1'b0;
      @(posedge clk);
      if (m_busy > 0) m_busy--;
      @(negedge clk);
      chk("R11 quiet", 32'(rsp_valid), 32'd0);
      chk("R7 busy", 32'(busy), 32'(m_busy != 0));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_wip = m_dr[0];
    m_busy = 0;
    chk_state("R1 recall");
    chk("R11 reset", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_dr[i] = INIT_V[i*W +: W];
    void'($urandom(32'h5EED));
    do_reset();
    chk("R2 high end", 32'(tap_sel[1023]), 32'd1);
    cmd(2'd1, 1'b1, 2'd0, 10'h000, "R3");
    chk("R2 low end", 32'(tap_sel[0]), 32'd1);
    for (int i = 0; i < N; i++) cmd(2'd0, 1'b0, 2'(i), '0, "R4");
    cmd(2'd0, 1'b1, 2'd0, '0, "R4");
    wp_n = 1'b0;
    cmd(2'd1, 1'b0, 2'd1, 10'h155, "R6");
    cmd(2'd3, 1'b0, 2'd2, '0, "R6 R10");
    cmd(2'd0, 1'b0, 2'd1, '0, "R6");
    cmd(2'd2, 1'b0, 2'd3, '0, "R9");
    cmd(2'd1, 1'b1, 2'd0, 10'h200, "R3");
    wp_n = 1'b1;
    cmd(2'd1, 1'b0, 2'd2, 10'h2AA, "R5");
    cmd(2'd1, 1'b0, 2'd3, 10'h111, "R8");
    cmd(2'd3, 1'b0, 2'd1, '0, "R8 R10");
    cmd(2'd2, 1'b0, 2'd2, '0, "R9");
    cmd(2'd1, 1'b1, 2'd0, 10'h0F0, "R3");
    idle(BC);
    cmd(2'd3, 1'b0, 2'd0, '0, "R10");
    cmd(2'd0, 1'b0, 2'd0, '0, "R10");
    idle(BC + 2);
    cmd(2'd1, 1'b1, 2'd0, 10'h3FF, "R3");
    do_reset();
    for (int k = 0; k < 400; k++) begin
      wp_n = ($urandom % 4) != 0;
      if ($urandom % 5 == 0) idle(1);
      else cmd(2'($urandom), 1'($urandom), 2'($urandom), W'($urandom), "R5 rand");
    end
    do_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule